// File: doc/BRIEF.md
# eMMC PHY Control Register Bank

This block is the software-visible control point for an eMMC physical layer. It keeps seven 16-bit control words and one read-only status word behind a small 32-bit request/response bus. A write never stores a plain word. The upper half of the write data is a per-bit enable for the lower half, so software can change one field, such as the power-up bit or the DLL enable, without first reading the register back.

The stored control bits are split into named fields and driven straight to the PHY: DLL frequency band, input and output tap delays, clock-buffer and strobe selects, per-lane receive enable, pull-up and open-drain controls, and the DLL and power controls. The PHY's calibration, DLL-lock, trim-result and presence flags are sampled every cycle and can be read at the status offset. The bus accepts one request at a time. Each accepted request is answered by a one-cycle response in the next cycle.

Top module: `emmc_phy_ctrl_regs`

## Requirements
- R1: Reset (`rst_n` low at a clock edge) clears all seven control words to 0x0000 and drives every field output to 0. After reset `req_ready` is 1 and `rsp_valid` is 0.
- R2: A write to a control word changes stored bit n (0..15) to `req_wdata[n]` only when `req_wdata[n+16]` is 1. Bits whose enable is 0 keep their previous value.
- R3: Control word k (k = 0..6) is at byte offset 4*k (0x00 to 0x18). A read returns the stored word in bits 15:0 and 0 in bits 31:16.
- R4: Word 0 fields: bits 13:12 `dll_freq_sel`, bit 11 `out_tap_en`, bits 10:7 `out_tap_sel`, bit 6 `in_tap_win`, bits 5:1 `in_tap_sel`, bit 0 `in_tap_en`.
- R5: Word 6 fields: bits 12:9 `cp_trim`, bit 8 `trim_en`, bit 7 `retrim`, bits 6:4 `drive_type`, bit 3 `hold_en_n`, bit 2 `hold_en`, bit 1 `dll_en`, bit 0 `pwr_up`.
- R6: Words 2, 3 and 5 drive receive enable, pull-up and open-drain enable with strobe in bit 9, command in bit 8 and data lanes in bits 7:0. Word 4 drives open-drain release with command in bit 9, strobe in bit 8 and lanes in bits 7:0.
- R7: Offset 0x20 reads the PHY status as calibration done in bit 6, DLL ready in bit 5, trim result in bits 4:1 and present in bit 0, with 0 elsewhere. The inputs are sampled one cycle before the read is accepted. Writes to 0x20 change nothing.
- R8: Reads of offset 0x1C, of any offset above 0x20, or of any address with bits 1:0 not zero return 0. Writes to those addresses change no control word.
- R9: A request is accepted on a clock edge where `req_valid` and `req_ready` are both 1. `rsp_valid` is 1 for exactly the following cycle and `req_ready` is 0 during it. Write responses carry 0 data.
- R10: Word 1 fields: bits 8:6 `clk_buf_sel`, bit 5 `tx_clk_dly_sel`, bit 4 `rx_clk_dly_sel`, bits 3:0 `strobe_sel`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Byte address |
| req_wdata | input | 32 | Bits 31:16 per-bit enable, bits 15:0 data |
| rsp_valid | output | 1 | Response present for one cycle |
| rsp_rdata | output | 32 | Read data (0 for writes) |
| st_cal_done | input | 1 | PHY calibration finished |
| st_dll_ready | input | 1 | DLL locked |
| st_trim | input | 4 | Trim result from the PHY |
| st_present | input | 1 | PHY instance present |
| dll_freq_sel | output | 2 | DLL frequency band |
| out_tap_en | output | 1 | Output tap delay enable |
| out_tap_sel | output | 4 | Output tap delay select |
| in_tap_win | output | 1 | Input tap change window |
| in_tap_sel | output | 5 | Input tap delay select |
| in_tap_en | output | 1 | Input tap delay enable |
| clk_buf_sel | output | 3 | Clock buffer select |
| tx_clk_dly_sel | output | 1 | Use delayed transmit clock |
| rx_clk_dly_sel | output | 1 | Use delayed receive clock |
| strobe_sel | output | 4 | Strobe delay select |
| rx_en_strb | output | 1 | Receive enable, strobe |
| rx_en_cmd | output | 1 | Receive enable, command |
| rx_en_dat | output | 8 | Receive enable, data lanes |
| pu_strb | output | 1 | Pull-up, strobe |
| pu_cmd | output | 1 | Pull-up, command |
| pu_dat | output | 8 | Pull-up, data lanes |
| odr_strb | output | 1 | Open-drain release, strobe |
| odr_cmd | output | 1 | Open-drain release, command |
| odr_dat | output | 8 | Open-drain release, data lanes |
| ode_strb | output | 1 | Open-drain enable, strobe |
| ode_cmd | output | 1 | Open-drain enable, command |
| ode_dat | output | 8 | Open-drain enable, data lanes |
| cp_trim | output | 4 | DLL charge-pump trim |
| trim_en | output | 1 | Resistor trim enable |
| retrim | output | 1 | Request retrim |
| drive_type | output | 3 | Output driver strength |
| hold_en_n | output | 1 | Retention control, active low |
| hold_en | output | 1 | Retention control |
| dll_en | output | 1 | DLL enable |
| pwr_up | output | 1 | PHY power up (0 = powered down) |

## Verification
The assertions assume that the bus inputs are driven to known values whenever reset is released. They also assume that a requester only counts a transfer on an edge where `req_ready` was high. The bench keeps to both: it changes inputs only on the falling edge, it waits for `req_ready` before raising `req_valid`, and it drops `req_valid` right after the accepting edge. The status check relies on the PHY flags being settled before the read. The bench changes the status inputs at least two cycles before it reads offset 0x20, so the sampled word equals the driven values.

// File: rtl/emmc_phy_regs_pkg.sv
// Package: shared constants for the eMMC PHY control register bank.
// Assumes word-aligned byte addressing with 4-byte register spacing.
package emmc_phy_regs_pkg;
    localparam int REG_W      = 16;   // stored bits per control word
    localparam int N_CTRL     = 7;    // number of control words
    localparam int STATUS_IDX = 8;    // word index of the status word (0x20)
    localparam int LANES      = 8;    // data lanes per pad-control word
    localparam int TRIM_W     = 4;    // trim result width

    // Word indices of the control words that feed the PHY
    localparam int W_TAPS  = 0;
    localparam int W_CLKS  = 1;
    localparam int W_RXEN  = 2;
    localparam int W_PULL  = 3;
    localparam int W_ODREL = 4;
    localparam int W_ODEN  = 5;
    localparam int W_DLL   = 6;
endpackage

// File: rtl/masked_field_reg.sv
// Module: one control word with per-bit write enables.
// Assumes wr_en is a single-cycle strobe from the bus front end.
module masked_field_reg #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic [W-1:0] wr_mask,
    output logic [W-1:0] q
);
    // Update only the enabled bits on a write; clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= '0;
        else if (wr_en)
            q <= (q & ~wr_mask) | (wr_data & wr_mask);
    end

    // R2: bits whose enable is clear keep their old value
    p_mask_keep_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> ((q ^ $past(q)) & ~$past(wr_mask)) == '0);
    // R2: enabled bits take the written data
    p_mask_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> ((q ^ $past(wr_data)) & $past(wr_mask)) == '0);
    // R8: without a strobe the word holds
    p_hold_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> q == $past(q));
endmodule

// File: rtl/status_capture.sv
// Module: samples the PHY status flags each cycle and packs the status word.
// Assumes the flags are quasi-static relative to software reads.
module status_capture #(
    parameter int REG_W  = 16,
    parameter int TRIM_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cal_done,
    input  logic              dll_ready,
    input  logic [TRIM_W-1:0] trim,
    input  logic              present,
    output logic [REG_W-1:0]  status_word
);
    localparam int TRIM_LSB = 1;
    localparam int DLL_BIT  = TRIM_LSB + TRIM_W;
    localparam int CAL_BIT  = DLL_BIT + 1;

    logic              cal_q, dll_q, pres_q;
    logic [TRIM_W-1:0] trim_q;

    // Register the raw PHY flags once per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cal_q  <= 1'b0;
            dll_q  <= 1'b0;
            pres_q <= 1'b0;
            trim_q <= '0;
        end else begin
            cal_q  <= cal_done;
            dll_q  <= dll_ready;
            pres_q <= present;
            trim_q <= trim;
        end
    end

    // Pack the sampled flags into their word positions.
    always_comb begin
        status_word                                  = '0;
        status_word[CAL_BIT]                         = cal_q;
        status_word[DLL_BIT]                         = dll_q;
        status_word[TRIM_LSB +: TRIM_W]              = trim_q;
        status_word[0]                               = pres_q;
    end

    // R7: the packed word follows the inputs one cycle later
    p_status_cal_r7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> status_word[CAL_BIT] == $past(cal_done));
    p_status_trim_r7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> status_word[TRIM_LSB +: TRIM_W] == $past(trim));
endmodule

// File: rtl/lane_ctl_decode.sv
// Module: splits a pad-control word into strobe, command and lane fields.
// SWAP_SC selects the variant with command above strobe.
module lane_ctl_decode #(
    parameter int LANES   = 8,
    parameter bit SWAP_SC = 1'b0
) (
    input  logic [LANES+1:0] word,
    output logic             strb,
    output logic             cmd,
    output logic [LANES-1:0] dat
);
    assign dat = word[LANES-1:0];

    // Pick the strobe/command layout for this word.
    generate
        if (SWAP_SC) begin : g_cmd_high
            assign cmd  = word[LANES+1];
            assign strb = word[LANES];
        end else begin : g_strb_high
            assign strb = word[LANES+1];
            assign cmd  = word[LANES];
        end
    endgenerate
endmodule

// File: rtl/bus_front.sv
// Module: request/response handshake, address decode and read mux.
// Assumes one outstanding request; ready drops while a response is shown.
module bus_front #(
    parameter int ADDR_W     = 8,
    parameter int REG_W      = 16,
    parameter int N_CTRL     = 7,
    parameter int STATUS_IDX = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    output logic                    req_ready,
    input  logic                    req_write,
    input  logic [ADDR_W-1:0]       req_addr,
    input  logic [2*REG_W-1:0]      req_wdata,
    output logic                    rsp_valid,
    output logic [2*REG_W-1:0]      rsp_rdata,
    input  logic [N_CTRL*REG_W-1:0] ctrl_flat,
    input  logic [REG_W-1:0]        status_word,
    output logic [N_CTRL-1:0]       wr_strobe,
    output logic [REG_W-1:0]        wr_data,
    output logic [REG_W-1:0]        wr_mask
);
    localparam int IDX_W = ADDR_W - 2;
    localparam int BUS_W = 2 * REG_W;

    logic             accept;
    logic             aligned;
    logic [IDX_W-1:0] idx;
    logic             hit_ctrl, hit_status;
    logic [REG_W-1:0] rd_ctrl;
    logic [BUS_W-1:0] rd_word;

    assign req_ready  = !rsp_valid;
    assign accept     = req_valid && req_ready;
    assign idx        = req_addr[ADDR_W-1:2];
    assign aligned    = (req_addr[1:0] == 2'b00);
    assign hit_ctrl   = aligned && (int'(idx) < N_CTRL);
    assign hit_status = aligned && (int'(idx) == STATUS_IDX);
    assign wr_data    = req_wdata[REG_W-1:0];
    assign wr_mask    = req_wdata[BUS_W-1:REG_W];

    // One write strobe per control word.
    generate
        for (genvar i = 0; i < N_CTRL; i++) begin : g_strobe
            assign wr_strobe[i] = accept && req_write && aligned && (int'(idx) == i);
        end
    endgenerate

    // Select the addressed control word.
    always_comb begin
        rd_ctrl = '0;
        for (int i = 0; i < N_CTRL; i++)
            if (int'(idx) == i) rd_ctrl = ctrl_flat[i*REG_W +: REG_W];
    end

    // Zero-extend the selected word; unmapped reads give zero.
    always_comb begin
        rd_word = '0;
        if (hit_ctrl)
            rd_word[REG_W-1:0] = rd_ctrl;
        else if (hit_status)
            rd_word[REG_W-1:0] = status_word;
    end

    // Produce a one-cycle response after every accepted request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= accept;
            if (accept)
                rsp_rdata <= req_write ? '0 : rd_word;
        end
    end

    // R9: every accepted request gets a response next cycle
    p_rsp_follows_r9: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> rsp_valid);
    // R9: a response lasts a single cycle
    p_rsp_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);
    // R8: unmapped reads return zero
    p_unmapped_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !req_write && !hit_ctrl && !hit_status) |=> rsp_rdata == '0);
    // R3: control reads have a zero upper half
    p_upper_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !req_write && hit_ctrl) |=> rsp_rdata[BUS_W-1:REG_W] == '0);
    // R3: at most one word is written per request
    p_one_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_strobe));
endmodule

// File: rtl/emmc_phy_ctrl_regs.sv
// Module: top of the eMMC PHY control register bank.
// Holds seven masked-write control words, decodes them into PHY fields and
// exposes sampled PHY status. Assumes a single requester on the bus.
module emmc_phy_ctrl_regs
    import emmc_phy_regs_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic          req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [31:0]   req_wdata,
    output logic          rsp_valid,
    output logic [31:0]   rsp_rdata,
    input  logic          st_cal_done,
    input  logic          st_dll_ready,
    input  logic [3:0]    st_trim,
    input  logic          st_present,
    output logic [1:0]    dll_freq_sel,
    output logic          out_tap_en,
    output logic [3:0]    out_tap_sel,
    output logic          in_tap_win,
    output logic [4:0]    in_tap_sel,
    output logic          in_tap_en,
    output logic [2:0]    clk_buf_sel,
    output logic          tx_clk_dly_sel,
    output logic          rx_clk_dly_sel,
    output logic [3:0]    strobe_sel,
    output logic          rx_en_strb,
    output logic          rx_en_cmd,
    output logic [7:0]    rx_en_dat,
    output logic          pu_strb,
    output logic          pu_cmd,
    output logic [7:0]    pu_dat,
    output logic          odr_strb,
    output logic          odr_cmd,
    output logic [7:0]    odr_dat,
    output logic          ode_strb,
    output logic          ode_cmd,
    output logic [7:0]    ode_dat,
    output logic [3:0]    cp_trim,
    output logic          trim_en,
    output logic          retrim,
    output logic [2:0]    drive_type,
    output logic          hold_en_n,
    output logic          hold_en,
    output logic          dll_en,
    output logic          pwr_up
);
    localparam int PAD_W = LANES + 2;

    logic [N_CTRL-1:0]       wr_strobe;
    logic [REG_W-1:0]        wr_data, wr_mask;
    logic [REG_W-1:0]        ctrl_q [N_CTRL];
    logic [N_CTRL*REG_W-1:0] ctrl_flat;
    logic [REG_W-1:0]        status_word;

    bus_front #(
        .ADDR_W(ADDR_W), .REG_W(REG_W), .N_CTRL(N_CTRL), .STATUS_IDX(STATUS_IDX)
    ) u_front (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .ctrl_flat(ctrl_flat), .status_word(status_word),
        .wr_strobe(wr_strobe), .wr_data(wr_data), .wr_mask(wr_mask)
    );

    // One masked register per control word.
    generate
        for (genvar k = 0; k < N_CTRL; k++) begin : g_ctrl
            masked_field_reg #(.W(REG_W)) u_reg (
                .clk(clk), .rst_n(rst_n), .wr_en(wr_strobe[k]),
                .wr_data(wr_data), .wr_mask(wr_mask), .q(ctrl_q[k])
            );
            assign ctrl_flat[k*REG_W +: REG_W] = ctrl_q[k];
        end
    endgenerate

    status_capture #(.REG_W(REG_W), .TRIM_W(TRIM_W)) u_status (
        .clk(clk), .rst_n(rst_n),
        .cal_done(st_cal_done), .dll_ready(st_dll_ready),
        .trim(st_trim), .present(st_present), .status_word(status_word)
    );

    // Tap and frequency fields (word 0).
    assign dll_freq_sel = ctrl_q[W_TAPS][13:12];
    assign out_tap_en   = ctrl_q[W_TAPS][11];
    assign out_tap_sel  = ctrl_q[W_TAPS][10:7];
    assign in_tap_win   = ctrl_q[W_TAPS][6];
    assign in_tap_sel   = ctrl_q[W_TAPS][5:1];
    assign in_tap_en    = ctrl_q[W_TAPS][0];

    // Clock routing fields (word 1).
    assign clk_buf_sel    = ctrl_q[W_CLKS][8:6];
    assign tx_clk_dly_sel = ctrl_q[W_CLKS][5];
    assign rx_clk_dly_sel = ctrl_q[W_CLKS][4];
    assign strobe_sel     = ctrl_q[W_CLKS][3:0];

    // Pad-control words; open-drain release uses the swapped layout.
    lane_ctl_decode #(.LANES(LANES), .SWAP_SC(1'b0)) u_rxen (
        .word(ctrl_q[W_RXEN][PAD_W-1:0]), .strb(rx_en_strb), .cmd(rx_en_cmd), .dat(rx_en_dat));
    lane_ctl_decode #(.LANES(LANES), .SWAP_SC(1'b0)) u_pull (
        .word(ctrl_q[W_PULL][PAD_W-1:0]), .strb(pu_strb), .cmd(pu_cmd), .dat(pu_dat));
    lane_ctl_decode #(.LANES(LANES), .SWAP_SC(1'b1)) u_odrel (
        .word(ctrl_q[W_ODREL][PAD_W-1:0]), .strb(odr_strb), .cmd(odr_cmd), .dat(odr_dat));
    lane_ctl_decode #(.LANES(LANES), .SWAP_SC(1'b0)) u_oden (
        .word(ctrl_q[W_ODEN][PAD_W-1:0]), .strb(ode_strb), .cmd(ode_cmd), .dat(ode_dat));

    // DLL, trim and power fields (word 6).
    assign cp_trim    = ctrl_q[W_DLL][12:9];
    assign trim_en    = ctrl_q[W_DLL][8];
    assign retrim     = ctrl_q[W_DLL][7];
    assign drive_type = ctrl_q[W_DLL][6:4];
    assign hold_en_n  = ctrl_q[W_DLL][3];
    assign hold_en    = ctrl_q[W_DLL][2];
    assign dll_en     = ctrl_q[W_DLL][1];
    assign pwr_up     = ctrl_q[W_DLL][0];

    // R5: power and DLL controls move only on an accepted write to word 6
    p_pwr_write_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_strobe[W_DLL] |=> ($stable(pwr_up) && $stable(dll_en)));
endmodule

// File: tb/emmc_phy_ctrl_regs_tb.sv
`timescale 1ns/1ps
module emmc_phy_ctrl_regs_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [7:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic req_ready, rsp_valid;
    logic [31:0] rsp_rdata;
    logic st_cal_done = 1'b0, st_dll_ready = 1'b0, st_present = 1'b0;
    logic [3:0] st_trim = '0;
    logic [1:0] dll_freq_sel; logic out_tap_en; logic [3:0] out_tap_sel;
    logic in_tap_win; logic [4:0] in_tap_sel; logic in_tap_en;
    logic [2:0] clk_buf_sel; logic tx_clk_dly_sel, rx_clk_dly_sel; logic [3:0] strobe_sel;
    logic rx_en_strb, rx_en_cmd, pu_strb, pu_cmd, odr_strb, odr_cmd, ode_strb, ode_cmd;
    logic [7:0] rx_en_dat, pu_dat, odr_dat, ode_dat;
    logic [3:0] cp_trim; logic trim_en, retrim; logic [2:0] drive_type;
    logic hold_en_n, hold_en, dll_en, pwr_up;

    int total = 0, bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    emmc_phy_ctrl_regs u_dut (.*);

    // Vector table: {byte address, write word, expected read-back}
    localparam int NV = 13;
    localparam logic [55:0] VEC [NV] = '{
        {8'h00, 32'hFFFF_A5C3, 16'hA5C3},
        {8'h00, 32'h00F0_0000, 16'hA503},
        {8'h00, 32'h0F00_FFFF, 16'hAF03},
        {8'h04, 32'h0000_FFFF, 16'h0000},
        {8'h04, 32'h01FF_0155, 16'h0155},
        {8'h08, 32'hFFFF_0303, 16'h0303},
        {8'h0C, 32'hFFFF_0281, 16'h0281},
        {8'h10, 32'hFFFF_0155, 16'h0155},
        {8'h14, 32'hFFFF_03AA, 16'h03AA},
        {8'h18, 32'hFFFF_1F3B, 16'h1F3B},
        {8'h18, 32'h0003_0000, 16'h1F38},
        {8'h1C, 32'hFFFF_FFFF, 16'h0000},
        {8'h40, 32'hFFFF_FFFF, 16'h0000}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic txn(input logic w, input logic [7:0] a, input logic [31:0] d,
                       output logic [31:0] r);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
        @(posedge clk); #1;
        req_valid = 1'b0;
        r = rsp_rdata;
    endtask

    logic [31:0] rd, dummy;
    logic any_field;
    assign any_field = |{dll_freq_sel, out_tap_en, out_tap_sel, in_tap_win, in_tap_sel,
        in_tap_en, clk_buf_sel, tx_clk_dly_sel, rx_clk_dly_sel, strobe_sel,
        rx_en_strb, rx_en_cmd, rx_en_dat, pu_strb, pu_cmd, pu_dat, odr_strb, odr_cmd,
        odr_dat, ode_strb, ode_cmd, ode_dat, cp_trim, trim_en, retrim, drive_type,
        hold_en_n, hold_en, dll_en, pwr_up};

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        @(negedge clk);
        chk("R1 fields zero after reset", {31'd0, any_field}, 32'd0);
        chk("R1 ready after reset", {31'd0, req_ready}, 32'd1);
        chk("R1 no response after reset", {31'd0, rsp_valid}, 32'd0);
        txn(1'b0, 8'h18, 32'd0, rd);
        chk("R1 word6 reset value", rd, 32'd0);

        // Table walk: write then read back each entry
        for (int i = 0; i < NV; i++) begin
            txn(1'b1, VEC[i][55:48], VEC[i][47:16], dummy);
            txn(1'b0, VEC[i][55:48], 32'd0, rd);
            chk($sformatf("R2 R3 R8 vector %0d", i), rd, {16'd0, VEC[i][15:0]});
        end

        // R8: unmapped writes left the mapped words intact
        txn(1'b0, 8'h00, 32'd0, rd); chk("R8 word0 intact", rd, 32'h0000_AF03);
        txn(1'b0, 8'h18, 32'd0, rd); chk("R8 word6 intact", rd, 32'h0000_1F38);
        txn(1'b1, 8'h01, 32'hFFFF_0000, dummy);
        txn(1'b0, 8'h00, 32'd0, rd); chk("R8 misaligned write ignored", rd, 32'h0000_AF03);
        txn(1'b0, 8'h02, 32'd0, rd); chk("R8 misaligned read zero", rd, 32'd0);

        // R4: word 0 = 0xAF03
        chk("R4 freq sel", {30'd0, dll_freq_sel}, 32'd2);
        chk("R4 out tap", {27'd0, out_tap_en, out_tap_sel}, 32'h1E);
        chk("R4 in tap", {25'd0, in_tap_win, in_tap_sel, in_tap_en}, 32'h03);
        // R10: word 1 = 0x0155
        chk("R10 clock fields", {23'd0, clk_buf_sel, tx_clk_dly_sel, rx_clk_dly_sel, strobe_sel},
            {23'd0, 3'd5, 1'b0, 1'b1, 4'd5});
        // R6: pad words, word 4 swapped
        chk("R6 rx enable", {22'd0, rx_en_strb, rx_en_cmd, rx_en_dat}, 32'h303);
        chk("R6 pull-up", {22'd0, pu_strb, pu_cmd, pu_dat}, 32'h281);
        chk("R6 od release swapped", {22'd0, odr_strb, odr_cmd, odr_dat}, {22'd0, 1'b1, 1'b0, 8'h55});
        chk("R6 od enable", {22'd0, ode_strb, ode_cmd, ode_dat}, 32'h3AA);
        // R5: word 6 = 0x1F38
        chk("R5 trim fields", {26'd0, cp_trim, trim_en, retrim}, {26'd0, 4'hF, 1'b1, 1'b0});
        chk("R5 drive and hold", {27'd0, drive_type, hold_en_n, hold_en}, {27'd0, 3'd3, 1'b1, 1'b0});
        chk("R5 dll/power off", {30'd0, dll_en, pwr_up}, 32'd0);
        txn(1'b1, 8'h18, 32'h0001_0001, dummy);
        @(negedge clk);
        chk("R5 power up only", {30'd0, dll_en, pwr_up}, 32'd1);
        txn(1'b1, 8'h18, 32'h0002_0002, dummy);
        @(negedge clk);
        chk("R5 dll enable", {30'd0, dll_en, pwr_up}, 32'd3);

        // R7: status sampling, writes ignored
        @(negedge clk);
        st_cal_done = 1'b1; st_dll_ready = 1'b0; st_trim = 4'hA; st_present = 1'b1;
        repeat (2) @(negedge clk);
        txn(1'b1, 8'h20, 32'hFFFF_FFFF, dummy);
        txn(1'b0, 8'h20, 32'd0, rd);
        chk("R7 status pattern A", rd, 32'h0000_0055);
        @(negedge clk);
        st_cal_done = 1'b0; st_dll_ready = 1'b1; st_trim = 4'h5; st_present = 1'b0;
        repeat (2) @(negedge clk);
        txn(1'b0, 8'h20, 32'd0, rd);
        chk("R7 status pattern B", rd, 32'h0000_002A);

        // R9: handshake timing
        txn(1'b0, 8'h04, 32'd0, rd);
        chk("R9 response valid", {30'd0, rsp_valid, req_ready}, 32'd2);
        @(posedge clk); #1;
        chk("R9 single-cycle response", {30'd0, rsp_valid, req_ready}, 32'd1);
        txn(1'b1, 8'h04, 32'hFFFF_1234, rd);
        chk("R9 write response data zero", rd, 32'd0);

        // R1: reset in mid-run clears words
        @(negedge clk) rst_n = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        @(negedge clk);
        chk("R1 fields zero after second reset", {31'd0, any_field}, 32'd0);
        txn(1'b0, 8'h04, 32'd0, rd);
        chk("R1 word1 cleared", rd, 32'd0);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog R9 act=hung exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule